// File: doc/BRIEF.md
# AXI4 Memory Fill-and-Verify Traffic Master

This block is an AXI4 master used to test a memory slave in place. After reset it fills a window of the memory that starts at address zero. Every word in the window receives a value taken from that word's own index, so the expected data is never stored. When the last write response has returned, the block issues read bursts over the same window without end. It compares each returned beat with the index of the word it came from.

A wrong beat raises a one-cycle error pulse and advances a saturating error counter. The write and read burst lengths are set separately. Each one is given as a power-of-two exponent, so every burst holds 2^n beats and a whole number of bursts covers the window. The window size is also a power-of-two exponent. A small window, such as the first 16 KB, can be tested without sweeping the whole device. The block issues no byte strobes, drives writes and reads in separate phases, and ignores response codes.

Top module: `axi_sweep_tester`

## Requirements
- R1: While reset is asserted, awvalid, wvalid and arvalid are low, err_pulse is low and err_count is zero.
- R2: Write bursts start at byte address 0 and ascend in steps of WR_BEATS*WORD_BYTES. Each carries awlen = WR_BEATS-1, where WR_BEATS = 2^WR_LOG2 and WORD_BYTES = DATA_W/8. Exactly 2^RGN_LOG2 / WR_BEATS bursts are issued.
- R3: The data of each write beat equals the word index of its target, truncated to DATA_W bits. The word index is the byte address shifted right by log2(WORD_BYTES). After the fill, word i of the window holds i.
- R4: wlast is high on the final beat of every write burst and low on every other beat. No further write beat follows it until a new address is accepted.
- R5: bready is held high. The next write address is presented only after the previous burst's response. No read address is presented before all write responses have returned, and no write traffic follows the fill.
- R6: Read bursts carry arlen = RD_BEATS-1, where RD_BEATS = 2^RD_LOG2. Their byte addresses ascend in steps of RD_BEATS*WORD_BYTES from 0 and wrap back to 0 after the last burst of the window, repeating forever.
- R7: Each accepted read beat whose data differs from its word index makes err_pulse high for exactly the next cycle and increments err_count at the same edge. Matching beats leave both unchanged.
- R8: err_count saturates at its all-ones value and stays there under further mismatches.
- R9: Once awvalid or arvalid is high, it stays high with a stable address until accepted. Once wvalid is high, it stays high with stable data until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address accepted |
| awaddr | output | ADDR_W | Write burst byte address |
| awlen | output | 8 | Write beats minus one |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data accepted |
| wdata | output | DATA_W | Write data |
| wlast | output | 1 | Final write beat of a burst |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready, held high |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address accepted |
| araddr | output | ADDR_W | Read burst byte address |
| arlen | output | 8 | Read beats minus one |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| rdata | input | DATA_W | Read data |
| err_pulse | output | 1 | One-cycle flag per mismatching beat |
| err_count | output | ERR_W | Saturating mismatch count |

## Verification
A corrupted word index in the writer shows up at once. The data on the very next accepted write beat is wrong, and so are the following burst address and the wlast position. A slipped reader index is visible in two places. The araddr of the next burst is wrong, and error pulses appear against a clean memory within the same burst. The reference model follows every handshake and every cycle of err_pulse and err_count. A fault in the error logger is therefore reported on the first cycle after the beat that exposes it, including the cycle where the counter should stop at its ceiling.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    typedef enum logic [2:0] {
        WS_INIT,
        WS_ADDR,
        WS_DATA,
        WS_RESP,
        WS_DONE
    } wr_state_e;

    typedef enum logic [1:0] {
        RS_WAIT,
        RS_ADDR,
        RS_DATA
    } rd_state_e;

endpackage

// File: rtl/sweep_writer.sv
module sweep_writer
    import sweep_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 16,
    parameter int IDX_W      = 13,
    parameter int BURST_LOG2 = 3,
    parameter int WORD_LOG2  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              awvalid,
    input  logic              awready,
    output logic [ADDR_W-1:0] awaddr,
    output logic [7:0]        awlen,
    output logic              wvalid,
    input  logic              wready,
    output logic [DATA_W-1:0] wdata,
    output logic              wlast,
    input  logic              bvalid,
    output logic              bready,
    output logic              done
);

    localparam logic [IDX_W-1:0] BMASK = IDX_W'((1 << BURST_LOG2) - 1);

    typedef struct packed {
        wr_state_e        st;
        logic [IDX_W-1:0] idx;
    } wr_regs_t;

    wr_regs_t q, d;
    logic     beat_last;

    assign beat_last = ((q.idx & BMASK) == BMASK);

    always_comb begin
        d = q;
        case (q.st)
            WS_INIT: d.st = WS_ADDR;
            WS_ADDR: if (awready) d.st = WS_DATA;
            WS_DATA: begin
                if (wready) begin
                    d.idx = q.idx + 1'b1;
                    if (beat_last) d.st = WS_RESP;
                end
            end
            WS_RESP: begin
                if (bvalid) d.st = (q.idx == '0) ? WS_DONE : WS_ADDR;
            end
            default: d.st = WS_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st  <= WS_INIT;
            q.idx <= '0;
        end else begin
            q <= d;
        end
    end

    assign awvalid = (q.st == WS_ADDR);
    assign awaddr  = ADDR_W'(q.idx) << WORD_LOG2;
    assign awlen   = 8'((1 << BURST_LOG2) - 1);
    assign wvalid  = (q.st == WS_DATA);
    assign wdata   = DATA_W'(q.idx);
    assign wlast   = wvalid && beat_last;
    assign bready  = 1'b1;
    assign done    = (q.st == WS_DONE);

    AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid && !awready |=> awvalid && $stable(awaddr)); // R9
    AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid && !wready |=> wvalid && $stable(wdata)); // R9
    AST_LAST_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid && wready && wlast |=> !wvalid); // R4
    AST_DONE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done && !awvalid); // R5

endmodule

// File: rtl/sweep_reader.sv
module sweep_reader
    import sweep_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 16,
    parameter int IDX_W      = 13,
    parameter int BURST_LOG2 = 3,
    parameter int WORD_LOG2  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              arvalid,
    input  logic              arready,
    output logic [ADDR_W-1:0] araddr,
    output logic [7:0]        arlen,
    input  logic              rvalid,
    output logic              rready,
    input  logic [DATA_W-1:0] rdata,
    output logic              mismatch
);

    localparam logic [IDX_W-1:0] BMASK = IDX_W'((1 << BURST_LOG2) - 1);

    typedef struct packed {
        rd_state_e        st;
        logic [IDX_W-1:0] idx;
    } rd_regs_t;

    rd_regs_t q, d;
    logic     beat_last;

    assign beat_last = ((q.idx & BMASK) == BMASK);

    always_comb begin
        d = q;
        case (q.st)
            RS_WAIT: if (start) d.st = RS_ADDR;
            RS_ADDR: if (arready) d.st = RS_DATA;
            RS_DATA: begin
                if (rvalid) begin
                    d.idx = q.idx + 1'b1;
                    if (beat_last) d.st = RS_ADDR;
                end
            end
            default: d.st = RS_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st  <= RS_WAIT;
            q.idx <= '0;
        end else begin
            q <= d;
        end
    end

    assign arvalid  = (q.st == RS_ADDR);
    assign araddr   = ADDR_W'(q.idx) << WORD_LOG2;
    assign arlen    = 8'((1 << BURST_LOG2) - 1);
    assign rready   = (q.st == RS_DATA);
    assign mismatch = rready && rvalid && (rdata != DATA_W'(q.idx));

    AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid && !arready |=> arvalid && $stable(araddr)); // R9
    AST_READ_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid |-> start); // R5

endmodule

// File: rtl/sweep_errlog.sv
module sweep_errlog #(
    parameter int ERR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mismatch,
    output logic             err_pulse,
    output logic [ERR_W-1:0] err_count
);

    typedef struct packed {
        logic             pulse;
        logic [ERR_W-1:0] cnt;
    } log_regs_t;

    log_regs_t q, d;

    always_comb begin
        d       = q;
        d.pulse = mismatch;
        if (mismatch && (q.cnt != '1)) d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.pulse <= 1'b0;
            q.cnt   <= '0;
        end else begin
            q <= d;
        end
    end

    assign err_pulse = q.pulse;
    assign err_count = q.cnt;

endmodule

// File: rtl/axi_sweep_tester.sv
module axi_sweep_tester #(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 16,
    parameter int RGN_LOG2 = 13,
    parameter int WR_LOG2  = 3,
    parameter int RD_LOG2  = 3,
    parameter int ERR_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              awvalid,
    input  logic              awready,
    output logic [ADDR_W-1:0] awaddr,
    output logic [7:0]        awlen,
    output logic              wvalid,
    input  logic              wready,
    output logic [DATA_W-1:0] wdata,
    output logic              wlast,
    input  logic              bvalid,
    output logic              bready,
    output logic              arvalid,
    input  logic              arready,
    output logic [ADDR_W-1:0] araddr,
    output logic [7:0]        arlen,
    input  logic              rvalid,
    output logic              rready,
    input  logic [DATA_W-1:0] rdata,
    output logic              err_pulse,
    output logic [ERR_W-1:0]  err_count
);

    localparam int WORD_LOG2 = $clog2(DATA_W / 8);

    logic fill_done;
    logic mismatch;

    sweep_writer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(RGN_LOG2),
        .BURST_LOG2(WR_LOG2), .WORD_LOG2(WORD_LOG2)
    ) u_wr (
        .clk(clk), .rst_n(rst_n),
        .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen),
        .wvalid(wvalid), .wready(wready), .wdata(wdata), .wlast(wlast),
        .bvalid(bvalid), .bready(bready), .done(fill_done)
    );

    sweep_reader #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(RGN_LOG2),
        .BURST_LOG2(RD_LOG2), .WORD_LOG2(WORD_LOG2)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .start(fill_done),
        .arvalid(arvalid), .arready(arready), .araddr(araddr), .arlen(arlen),
        .rvalid(rvalid), .rready(rready), .rdata(rdata), .mismatch(mismatch)
    );

    sweep_errlog #(.ERR_W(ERR_W)) u_log (
        .clk(clk), .rst_n(rst_n), .mismatch(mismatch),
        .err_pulse(err_pulse), .err_count(err_count)
    );

    AST_CNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !err_pulse |-> $stable(err_count)); // R7
    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_count) == {ERR_W{1'b1}} |-> err_count == {ERR_W{1'b1}}); // R8
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(arvalid && (awvalid || wvalid))); // R5

endmodule

// File: tb/sim_axi_sweep_tester.sv
`timescale 1ns/1ps
module sim_axi_sweep_tester;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int RGN    = 6;
    localparam int WL     = 2;
    localparam int RL     = 3;
    localparam int ERR_W  = 4;
    localparam int WORDS  = 1 << RGN;
    localparam int WB     = 1 << WL;
    localparam int RB     = 1 << RL;
    localparam int BYTES  = DATA_W / 8;
    localparam int ERRMAX = (1 << ERR_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              awvalid, awready, wvalid, wready, wlast, bvalid, bready;
    logic              arvalid, arready, rvalid, rready, err_pulse;
    logic [ADDR_W-1:0] awaddr, araddr;
    logic [7:0]        awlen, arlen;
    logic [DATA_W-1:0] wdata, rdata;
    logic [ERR_W-1:0]  err_count;

    axi_sweep_tester #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RGN_LOG2(RGN),
        .WR_LOG2(WL), .RD_LOG2(RL), .ERR_W(ERR_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen),
        .wvalid(wvalid), .wready(wready), .wdata(wdata), .wlast(wlast),
        .bvalid(bvalid), .bready(bready),
        .arvalid(arvalid), .arready(arready), .araddr(araddr), .arlen(arlen),
        .rvalid(rvalid), .rready(rready), .rdata(rdata),
        .err_pulse(err_pulse), .err_count(err_count)
    );

    // behavioural memory slave
    logic [DATA_W-1:0] mem  [0:WORDS-1];
    logic [DATA_W-1:0] flip [0:WORDS-1];
    int  cyc;
    int  wp, rp, rleft;
    bit  w_open, r_open;

    always @(posedge clk) begin
        if (!rst_n) begin
            awready <= 0; wready <= 0; bvalid <= 0; arready <= 0; rvalid <= 0;
            rdata <= '0; cyc <= 0; wp <= 0; rp <= 0; rleft <= 0;
            w_open <= 0; r_open <= 0;
        end else begin
            cyc <= cyc + 1;
            if (awvalid && awready) begin
                wp <= int'(awaddr) / BYTES % WORDS; w_open <= 1; awready <= 0;
            end else awready <= !w_open && !bvalid && (cyc % 3 != 1);
            if (wvalid && wready) begin
                mem[wp] <= wdata; wp <= (wp + 1) % WORDS;
                if (wlast) begin w_open <= 0; bvalid <= 1; wready <= 0; end
                else wready <= (cyc % 4 != 2);
            end else wready <= w_open && (cyc % 4 != 2);
            if (bvalid && bready) bvalid <= 0;
            if (arvalid && arready) begin
                rp <= int'(araddr) / BYTES % WORDS; rleft <= int'(arlen) + 1;
                r_open <= 1; arready <= 0;
            end else arready <= !r_open && (cyc % 5 != 3);
            if (!rvalid || rready) begin
                if (r_open && rleft > 0 && (cyc % 3 != 0)) begin
                    rvalid <= 1; rdata <= mem[rp] ^ flip[rp];
                    rp <= (rp + 1) % WORDS; rleft <= rleft - 1;
                end else rvalid <= 0;
            end
            if (rvalid && rready && rleft == 0 && !(r_open && (cyc % 3 != 0) && rleft > 0))
                r_open <= 0;
        end
    end

    int nchk = 0, nerr = 0;
    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // reference model, evaluated every clock away from the active edge
    int  exp_aw, w_idx, bcount, exp_ar, r_idx, passes, exp_cnt;
    bit  pend;
    bit  p_awv, p_awr, p_arv, p_arr, p_wv, p_wr;
    logic [ADDR_W-1:0] p_awa, p_ara;
    logic [DATA_W-1:0] p_wd;

    always @(negedge clk) begin
        if (!rst_n) begin
            exp_aw = 0; w_idx = 0; bcount = 0; exp_ar = 0; r_idx = 0;
            passes = 0; exp_cnt = 0; pend = 0;
            p_awv = 0; p_awr = 0; p_arv = 0; p_arr = 0; p_wv = 0; p_wr = 0;
        end else begin
            check(err_pulse == pend, "R7 error pulse", err_pulse, pend);
            check(int'(err_count) == exp_cnt, "R7 R8 error count", err_count, exp_cnt);
            if (p_awv && !p_awr)
                check(awvalid && awaddr == p_awa, "R9 aw hold", awaddr, p_awa);
            if (p_arv && !p_arr)
                check(arvalid && araddr == p_ara, "R9 ar hold", araddr, p_ara);
            if (p_wv && !p_wr)
                check(wvalid && wdata == p_wd, "R9 w hold", wdata, p_wd);
            if (awvalid && awready) begin
                check(int'(awaddr) == exp_aw * BYTES, "R2 awaddr", awaddr, exp_aw * BYTES);
                check(int'(awlen) == WB - 1, "R2 awlen", awlen, WB - 1);
                exp_aw = (exp_aw + WB) % WORDS;
            end
            if (wvalid && wready) begin
                check(wdata == DATA_W'(w_idx), "R3 wdata", wdata, w_idx);
                check(wlast == ((w_idx % WB) == WB - 1), "R4 wlast", wlast, (w_idx % WB) == WB - 1);
                w_idx = (w_idx + 1) % WORDS;
            end
            if (bvalid) check(bready == 1'b1, "R5 bready", bready, 1);
            if (bvalid && bready) bcount++;
            if (bcount >= WORDS / WB)
                check(!awvalid && !wvalid, "R5 write after fill", awvalid, 0);
            if (arvalid)
                check(bcount == WORDS / WB, "R5 read before fill", bcount, WORDS / WB);
            if (arvalid && arready) begin
                check(int'(araddr) == exp_ar * BYTES, "R6 araddr", araddr, exp_ar * BYTES);
                check(int'(arlen) == RB - 1, "R6 arlen", arlen, RB - 1);
                if (exp_ar == 0) passes++;
                r_idx = exp_ar;
                exp_ar = (exp_ar + RB) % WORDS;
            end
            pend = 0;
            if (rvalid && rready) begin
                pend = (rdata != DATA_W'(r_idx));
                if (pend && exp_cnt < ERRMAX) exp_cnt++;
                r_idx++;
            end
            p_awv = awvalid; p_awr = awready; p_awa = awaddr;
            p_arv = arvalid; p_arr = arready; p_ara = araddr;
            p_wv = wvalid; p_wr = wready; p_wd = wdata;
        end
    end

    bit timed_out = 0;
    task automatic wait_passes(input int n);
        int k = 0;
        while (passes < n && k < 20000) begin
            @(negedge clk);
            k++;
        end
        if (k >= 20000) begin
            timed_out = 1;
            nchk++; nerr++;
            $display("FAIL watchdog: actual %0d passes expected %0d", passes, n);
        end
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) begin flip[i] = '0; mem[i] = '1; end
        repeat (4) @(negedge clk);
        check(!awvalid && !wvalid && !arvalid && !err_pulse && err_count == 0,
              "R1 reset state", {awvalid, wvalid, arvalid, err_pulse}, 0);
        rst_n = 1;
        wait_passes(2);
        if (!timed_out) begin
            for (int i = 0; i < WORDS; i++)
                check(mem[i] == DATA_W'(i), "R3 filled word", mem[i], i);
            check(err_count == 0, "R7 clean memory gives no error", err_count, 0);
            flip[5] = 16'h0100;
            wait_passes(5);
        end
        if (!timed_out) begin
            check(err_count >= 2, "R7 injected corruption detected", err_count, 2);
            check(passes >= 5, "R6 passes repeat", passes, 5);
            flip[12] = 16'h0001; flip[33] = 16'h8000; flip[63] = 16'h0040;
            wait_passes(10);
        end
        if (!timed_out) begin
            check(int'(err_count) == ERRMAX, "R8 count saturated", err_count, ERRMAX);
            wait_passes(12);
        end
        if (!timed_out)
            check(int'(err_count) == ERRMAX, "R8 count holds at ceiling", err_count, ERRMAX);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule